// File: doc/BRIEF.md
# Cascadable One-Hot Priority Resolver

The block turns a wide request vector into a one-hot grant vector, and the lowest-numbered active request wins. It is built from identical 8-bit cells chained in series. Each cell is split into two 4-bit groups. A single internal blocking term lets any request in the lower group silence the upper group. Between cells, an active-low look-ahead line tells the next cell that a stronger cell already holds priority.

The whole block is combinational in the requests, the look-ahead input and the level of a phase clock. While the clock is low, every grant is held at zero. While the clock is high, the grants follow the inputs directly. If priority is taken away or handed over in the middle of a high phase, the grants therefore react at once, without waiting for the next phase. The chain's own look-ahead input is brought out so that the resolver can itself sit behind a stronger stage. It is driven low when the resolver stands alone.

Top module: `pr_chain`

## Requirements
- R1: While phase_clk is 1 and chain_la_n is 0, grant bit i is 1 exactly when req bit i is 1 and every req bit below i is 0. Bit 0 is the strongest.
- R2: While chain_la_n is 1, every grant bit is 0, whatever the requests and the clock level.
- R3: While phase_clk is 0, every grant bit and any_grant are 0.
- R4: At most one grant bit is 1 at any time.
- R5: Within one 8-bit cell, a request in bits 0 to 3 of the cell blocks every grant in bits 4 to 7 of that cell. Requests in bits 4 to 7 never change the grants of bits 0 to 3.
- R6: Cell k covers bits 8k to 8k+7. Any request in a cell below k blocks all grants of cell k. A request in cell k blocks every cell above it.
- R7: If chain_la_n rises during a high phase, every grant drops in that same phase. If it falls during a high phase, the correct grant appears in that same phase.
- R8: any_grant is 1 exactly when phase_clk is 1, chain_la_n is 0 and at least one req bit is 1. This matches whether any grant bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase_clk | input | 1 | Phase clock: low holds grants at zero, high lets them evaluate |
| chain_la_n | input | 1 | Active-low look-ahead into the first cell (1 means a stronger stage owns priority) |
| req | input | N_CELLS*2*GRP_W | Request vector, bit 0 strongest |
| grant | output | N_CELLS*2*GRP_W | One-hot grant vector |
| any_grant | output | 1 | High while some grant bit is set |

## Verification
The bench builds the default chain of eight cells with 4-bit groups, which gives 64 bits. Every 8-bit request pattern is swept in cell 0 and again in cell 3, with each look-ahead value and both clock levels. In cell 3 the cells below are kept empty, so the pattern reaches the cell through real look-ahead hand-offs. Random 64-bit vectors, single-bit walks and sparse vectors reach the cell and group boundaries, and a mid-phase toggle of the look-ahead input exercises the immediate clear and assert.

// File: rtl/pr_pkg.sv
package pr_pkg;
  localparam int CELL_GROUPS = 2;
  localparam int DEF_GRP_W   = 4;
  localparam int DEF_CELLS   = 8;
endpackage

// File: rtl/pr_group.sv
module pr_group #(
  parameter int GRP_W = 4
) (
  input  logic             phase_clk,
  input  logic             blk_n,
  input  logic [GRP_W-1:0] req,
  output logic [GRP_W-1:0] grant,
  output logic             any_req
);
  logic             en;
  logic [GRP_W-1:0] seen;

  assign en      = phase_clk & ~blk_n;
  assign any_req = |req;
  assign seen[0] = 1'b0;

  for (genvar i = 1; i < GRP_W; i++) begin : g_seen
    assign seen[i] = seen[i-1] | req[i-1];
  end

  for (genvar i = 0; i < GRP_W; i++) begin : g_gnt
    assign grant[i] = en & req[i] & ~seen[i];
  end

  always_comb begin
    // R4
    grp_onehot_chk: assert ($onehot0(grant));
    // R3
    grp_lowphase_chk: assert (phase_clk || grant == '0);
  end
endmodule

// File: rtl/pr_cell.sv
module pr_cell
  import pr_pkg::*;
#(
  parameter int GRP_W = DEF_GRP_W,
  localparam int CW = CELL_GROUPS * GRP_W
) (
  input  logic          phase_clk,
  input  logic          la_in_n,
  input  logic [CW-1:0] req,
  output logic [CW-1:0] grant,
  output logic          la_out_n
);
  logic lo_any, hi_any;
  logic mid_blk_n;

  pr_group #(.GRP_W(GRP_W)) u_lo (
    .phase_clk (phase_clk),
    .blk_n     (la_in_n),
    .req       (req[GRP_W-1:0]),
    .grant     (grant[GRP_W-1:0]),
    .any_req   (lo_any)
  );

  // internal blocking term for the upper group, held low in the low phase
  assign mid_blk_n = phase_clk & (la_in_n | lo_any);

  pr_group #(.GRP_W(GRP_W)) u_hi (
    .phase_clk (phase_clk),
    .blk_n     (mid_blk_n),
    .req       (req[CW-1:GRP_W]),
    .grant     (grant[CW-1:GRP_W]),
    .any_req   (hi_any)
  );

  assign la_out_n = la_in_n | lo_any | hi_any;

  always_comb begin
    // R2
    cell_blocked_chk: assert (!la_in_n || grant == '0);
    // R5
    cell_split_chk: assert (!lo_any || grant[CW-1:GRP_W] == '0);
  end
endmodule

// File: rtl/pr_chain.sv
module pr_chain
  import pr_pkg::*;
#(
  parameter int N_CELLS = DEF_CELLS,
  parameter int GRP_W   = DEF_GRP_W,
  localparam int CW = CELL_GROUPS * GRP_W,
  localparam int W  = N_CELLS * CW
) (
  input  logic         phase_clk,
  input  logic         chain_la_n,
  input  logic [W-1:0] req,
  output logic [W-1:0] grant,
  output logic         any_grant
);
  logic [N_CELLS:0] la_n;

  assign la_n[0] = chain_la_n;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    pr_cell #(.GRP_W(GRP_W)) u_cell (
      .phase_clk (phase_clk),
      .la_in_n   (la_n[k]),
      .req       (req[k*CW +: CW]),
      .grant     (grant[k*CW +: CW]),
      .la_out_n  (la_n[k+1])
    );

    if (k > 0) begin : g_chk
      always_comb begin
        // R6
        cell_order_chk: assert (grant[k*CW +: CW] == '0 || req[k*CW-1:0] == '0);
      end
    end
  end

  assign any_grant = phase_clk & ~chain_la_n & la_n[N_CELLS];

  always_comb begin
    // R8
    any_match_chk: assert (any_grant == (grant != '0));
    // R4
    chain_onehot_chk: assert ($onehot0(grant));
  end
endmodule

// File: tb/sim_pr_chain.sv
`timescale 1ns/100ps
module sim_pr_chain;
  localparam int N_CELLS = 8;
  localparam int GRP_W   = 4;
  localparam int CW      = 2 * GRP_W;
  localparam int W       = N_CELLS * CW;

  logic         clk = 1'b0;
  logic         la_n = 1'b0;
  logic [W-1:0] req = '0;
  logic [W-1:0] grant;
  logic         any_grant;
  int           total = 0;
  int           bad = 0;

  pr_chain #(.N_CELLS(N_CELLS), .GRP_W(GRP_W)) u0 (
    .phase_clk  (clk),
    .chain_la_n (la_n),
    .req        (req),
    .grant      (grant),
    .any_grant  (any_grant)
  );

  always #2 clk = ~clk;

  function automatic logic [W-1:0] model(input logic [W-1:0] r, input logic l, input logic ph);
    logic [W-1:0] g = '0;
    if (ph && !l) begin
      for (int i = 0; i < W; i++) begin
        if (r[i]) begin
          g[i] = 1'b1;
          break;
        end
      end
    end
    return g;
  endfunction

  task automatic check(input string tag);
    logic [W-1:0] eg = model(req, la_n, clk);
    logic         ea = (eg != '0);
    total++;
    if (grant !== eg || any_grant !== ea) begin
      bad++;
      $display("FAIL %s: req=%h la_n=%b clk=%b grant=%h any=%b expected grant=%h any=%b",
               tag, req, la_n, clk, grant, any_grant, eg, ea);
    end
  endtask

  task automatic apply(input logic [W-1:0] r, input logic l, input string tag);
    @(negedge clk);
    req = r; la_n = l;
    #1 check({tag, " low phase R3"});
    @(posedge clk);
    #1 check(tag);
  endtask

  function automatic logic [W-1:0] rnd();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #1 check("reset state R3");
    // exhaustive in cell 0: R1 R2 R5
    for (int p = 0; p < 256; p++) begin
      for (int l = 0; l < 2; l++) begin
        apply({rnd() >> CW, 8'(p)}, l[0], "cell0 sweep R1 R2 R5");
      end
    end
    // exhaustive in cell 3 behind empty cells: R6
    for (int p = 0; p < 256; p++) begin
      for (int l = 0; l < 2; l++) begin
        logic [W-1:0] r = rnd();
        r[4*CW-1:0] = '0;
        r[3*CW +: CW] = 8'(p);
        apply(r, l[0], "cell3 sweep R6 R2");
      end
    end
    // single-bit walk across boundaries: R1 R6
    for (int i = 0; i < W; i++) begin
      apply(W'(1) << i, 1'b0, "walk R1 R6");
    end
    // sparse and random: R1 R4 R8
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] r = rnd();
      if (n % 2 == 1) r = r & rnd() & rnd() & rnd() & rnd();
      if (n % 7 == 0) r = '0;
      apply(r, 1'b0, "random R1 R4 R8");
    end
    // mid-phase look-ahead changes: R7
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      req = rnd() & rnd() & rnd();
      req[n*3] = 1'b1;
      la_n = 1'b0;
      @(posedge clk);
      #0.5 check("R7 before rise");
      la_n = 1'b1;
      #0.5 check("R7 after rise");
      la_n = 1'b0;
      #0.5 check("R7 after fall");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule